// File: doc/BRIEF.md
# Double-Buffered Timer-Based PWM Generator

This block produces one pulse-width modulated output from an 8-bit timer that advances once every four input clocks multiplied by a selectable prescale factor of 1, 4 or 16. The timer counts from zero up to a programmed period value and then wraps. The wrap marks the start of a new PWM cycle. At that point the output rises, and the duty value that software has queued becomes the active one.

The duty value is 10 bits wide. It is loaded through an 8-bit coarse field and a 2-bit fine field, both captured on a single write strobe. Writes land in a shadow register at any time and only reach the comparator at the next wrap, so a change in the middle of a cycle never cuts a pulse short or stretches it. The comparator works on a 10-bit time base. This time base holds the timer value above two fine bits. The fine bits come from the four-phase sub-cycle count at 1:1 prescale and from the two low prescaler bits otherwise. The output falls when the time base reaches the active duty value. A single-clock match pulse marks every wrap, and the active duty value can be read on its own port.

Top module: `pwm_dbuf_gen`

## Requirements
- R1: One PWM cycle lasts (period_i + 1) × 4 × N clocks. N is 1 for psel_i = 2'b00, 4 for 2'b01, and 16 for 2'b10 or 2'b11.
- R2: match_o is high for exactly one clock at the start of every cycle. In that same clock duty_act_o already shows the newly latched duty value, and pwm_o can rise only in that clock.
- R3: A clock with duty_wr_i high captures the queued duty as {duty_hi_i, duty_lo_i}. duty_hi_i forms bits 9:2 and duty_lo_i forms bits 1:0.
- R4: For an active duty D with 0 < D ≤ 4·period_i + 3, pwm_o is high for the first D clocks of the cycle at N = 1, for 4·D clocks at N = 4, and for 64·(D>>2) + 4·(D&3) clocks at N = 16.
- R5: A duty write has no effect on pwm_o or duty_act_o during the cycle in which it occurs. duty_act_o changes only at a cycle start.
- R6: An active duty of zero keeps pwm_o low for the whole cycle.
- R7: An active duty above 4·period_i + 3 keeps pwm_o high for the whole cycle.
- R8: While en_i is low, pwm_o and match_o are low and the timer does not advance, so the cycle lengthens by the number of disabled clocks. Once en_i returns high, pwm_o stays low until the next cycle start.
- R9: After a synchronous reset, pwm_o, match_o and duty_act_o are zero, the queued duty is zero, and the timer restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low freezes the timer and forces the output low |
| psel_i | input | 2 | Prescale select: 00 = 1:1, 01 = 1:4, 1x = 1:16 |
| period_i | input | 8 | Terminal timer value of a cycle |
| duty_hi_i | input | 8 | Coarse part of the queued duty (bits 9:2) |
| duty_lo_i | input | 2 | Fine part of the queued duty (bits 1:0) |
| duty_wr_i | input | 1 | Write strobe for the queued duty |
| pwm_o | output | 1 | PWM output, registered |
| duty_act_o | output | 10 | Active duty value in use this cycle |
| match_o | output | 1 | One-clock pulse at each cycle start |

## Verification
A timer or prescaler that steps wrongly shows at the ports as a wrong spacing between match_o pulses, so it appears within one cycle. A fault in the fine-bit selection or in the compare changes the number of high clocks counted between two pulses, which also appears within one cycle. A shadow or latch fault appears as duty_act_o moving between pulses, or as a cycle that uses a value written during the cycle before it. An enable fault appears as activity during the disabled window, or as a cycle length that does not grow by exactly the number of disabled clocks.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

  // number of sub-timer bits appended below the timer in the compare base
  localparam int FINE_W = 2;

  typedef enum logic [1:0] {
    PS_DIV1      = 2'b00,
    PS_DIV4      = 2'b01,
    PS_DIV16     = 2'b10,
    PS_DIV16_ALT = 2'b11
  } pscale_e;

endpackage

// File: rtl/pwm_dbuf_timebase.sv
module pwm_dbuf_timebase
  import pwm_dbuf_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int PRE_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  pscale_e                 psel,
  input  logic [TMR_W-1:0]        period,
  output logic [TMR_W+FINE_W-1:0] base_nxt,
  output logic                    wrap_nxt
);

  logic [FINE_W-1:0] ph_q, ph_d, fine_d;
  logic [PRE_W-1:0]  pre_q, pre_d, pre_lim;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic              step;

  // terminal prescaler count per mode
  always_comb begin
    case (psel)
      PS_DIV1: pre_lim = '0;
      PS_DIV4: pre_lim = PRE_W'(3);
      default: pre_lim = '1;
    endcase
  end

  always_comb begin
    ph_d     = ph_q;
    pre_d    = pre_q;
    tmr_d    = tmr_q;
    step     = 1'b0;
    wrap_nxt = 1'b0;
    if (en) begin
      ph_d = ph_q + 1'b1;
      if (&ph_q) begin
        if (pre_q >= pre_lim) begin
          pre_d = '0;
          step  = 1'b1;
        end else begin
          pre_d = pre_q + 1'b1;
        end
      end
    end
    if (step) begin
      if (tmr_q == period) begin
        tmr_d    = '0;
        wrap_nxt = 1'b1;
      end else begin
        tmr_d = tmr_q + 1'b1;
      end
    end
  end

  // fine bits: sub-cycle phase at 1:1, low prescaler bits otherwise
  assign fine_d   = (psel == PS_DIV1) ? ph_d : pre_d[FINE_W-1:0];
  assign base_nxt = {tmr_d, fine_d};

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= '0;
      pre_q <= '0;
      tmr_q <= '0;
    end else begin
      ph_q  <= ph_d;
      pre_q <= pre_d;
      tmr_q <= tmr_d;
    end
  end

endmodule

// File: rtl/pwm_dbuf_duty.sv
module pwm_dbuf_duty #(
  parameter int HI_W = 8,
  parameter int LO_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [HI_W-1:0]      hi,
  input  logic [LO_W-1:0]      lo,
  input  logic                 load,
  output logic [HI_W+LO_W-1:0] act_q,
  output logic [HI_W+LO_W-1:0] act_nxt
);

  logic [HI_W+LO_W-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (rst)     shadow_q <= '0;
    else if (wr) shadow_q <= {hi, lo};
  end

  // active copy moves only on the period wrap
  assign act_nxt = load ? shadow_q : act_q;

  always_ff @(posedge clk) begin
    if (rst) act_q <= '0;
    else     act_q <= act_nxt;
  end

endmodule

// File: rtl/pwm_dbuf_out.sv
module pwm_dbuf_out #(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wrap,
  input  logic [DUTY_W-1:0] base_nxt,
  input  logic [DUTY_W-1:0] act_nxt,
  output logic              pwm_q,
  output logic              match_q
);

  logic pwm_d;

  // compare against next-cycle values so the registered pin is exact
  always_comb begin
    if (!en)                       pwm_d = 1'b0;
    else if (base_nxt == act_nxt)  pwm_d = 1'b0;
    else if (wrap)                 pwm_d = 1'b1;
    else                           pwm_d = pwm_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      pwm_q   <= pwm_d;
      match_q <= wrap;
    end
  end

endmodule

// File: rtl/pwm_dbuf_gen.sv
module pwm_dbuf_gen
  import pwm_dbuf_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int PRE_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en_i,
  input  logic [1:0]              psel_i,
  input  logic [TMR_W-1:0]        period_i,
  input  logic [TMR_W-1:0]        duty_hi_i,
  input  logic [FINE_W-1:0]       duty_lo_i,
  input  logic                    duty_wr_i,
  output logic                    pwm_o,
  output logic [TMR_W+FINE_W-1:0] duty_act_o,
  output logic                    match_o
);

  localparam int DUTY_W = TMR_W + FINE_W;

  logic [DUTY_W-1:0] base_nxt;
  logic [DUTY_W-1:0] act_nxt;
  logic              wrap_nxt;

  pwm_dbuf_timebase #(
    .TMR_W (TMR_W),
    .PRE_W (PRE_W)
  ) i_tb (
    .clk      (clk),
    .rst      (rst),
    .en       (en_i),
    .psel     (pscale_e'(psel_i)),
    .period   (period_i),
    .base_nxt (base_nxt),
    .wrap_nxt (wrap_nxt)
  );

  pwm_dbuf_duty #(
    .HI_W (TMR_W),
    .LO_W (FINE_W)
  ) i_duty (
    .clk     (clk),
    .rst     (rst),
    .wr      (duty_wr_i),
    .hi      (duty_hi_i),
    .lo      (duty_lo_i),
    .load    (wrap_nxt),
    .act_q   (duty_act_o),
    .act_nxt (act_nxt)
  );

  pwm_dbuf_out #(
    .DUTY_W (DUTY_W)
  ) i_out (
    .clk      (clk),
    .rst      (rst),
    .en       (en_i),
    .wrap     (wrap_nxt),
    .base_nxt (base_nxt),
    .act_nxt  (act_nxt),
    .pwm_q    (pwm_o),
    .match_q  (match_o)
  );

endmodule

// File: rtl/pwm_dbuf_gen_chk.sv
module pwm_dbuf_gen_chk #(
  parameter int DUTY_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              en_i,
  input logic              pwm_o,
  input logic              match_o,
  input logic [DUTY_W-1:0] duty_act_o
);

  // R6: zero active duty never drives the pin high
  p_zero_low_r6: assert property (@(posedge clk) disable iff (rst)
    (duty_act_o == '0) |-> !pwm_o);

  // R8: disable forces pin and match low on the next clock
  p_en_low_r8: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!pwm_o && !match_o));

  // R5: active duty only moves together with a match pulse
  p_act_change_r5: assert property (@(posedge clk) disable iff (rst)
    (duty_act_o != $past(duty_act_o)) |-> match_o);

  // R2: match is a single-clock pulse
  p_match_single_r2: assert property (@(posedge clk) disable iff (rst)
    match_o |=> !match_o);

  // R2: the pin rises only at a cycle start
  p_rise_at_match_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_o) |-> match_o);

endmodule

bind pwm_dbuf_gen pwm_dbuf_gen_chk #(.DUTY_W(DUTY_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .en_i       (en_i),
  .pwm_o      (pwm_o),
  .match_o    (match_o),
  .duty_act_o (duty_act_o)
);

// File: tb/test_pwm_dbuf_gen.sv
`timescale 1ns/1ps
module test_pwm_dbuf_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_i = 1'b0;
  logic [1:0] psel_i = 2'b00;
  logic [7:0] period_i = 8'd9;
  logic [7:0] duty_hi_i = '0;
  logic [1:0] duty_lo_i = '0;
  logic       duty_wr_i = 1'b0;
  logic       pwm_o;
  logic [9:0] duty_act_o;
  logic       match_o;

  always #2 clk = ~clk;

  pwm_dbuf_gen i_pwm_dbuf_gen (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .psel_i     (psel_i),
    .period_i   (period_i),
    .duty_hi_i  (duty_hi_i),
    .duty_lo_i  (duty_lo_i),
    .duty_wr_i  (duty_wr_i),
    .pwm_o      (pwm_o),
    .duty_act_o (duty_act_o),
    .match_o    (match_o)
  );

  typedef struct {
    int    d;
    int    len;
    int    high;
    string tag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  int    pend = 0;
  int    cur_p = 9;
  int    cur_n = 1;
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_high(input int d, input int p, input int n);
    int maxb = 4*p + 3;
    int len  = (p + 1) * 4 * n;
    if (d == 0)   return 0;
    if (d > maxb) return len;
    if (n == 1)   return d;
    if (n == 4)   return 4*d;
    return 64*(d >> 2) + 4*(d & 3);
  endfunction

  // scoreboard monitor: measures each cycle between match pulses
  int cnt_len = 0, cnt_high = 0, last_act = 0;
  bit armed = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      q.delete();
      armed = 1'b0;
    end else if (match_o) begin
      if (armed && q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(cnt_len == it.len, "R1 cycle length", cnt_len, it.len);
        chk(cnt_high == it.high, it.tag, cnt_high, it.high);
        chk(last_act == it.d, "R5 active duty held", last_act, it.d);
      end
      armed    = 1'b1;
      cnt_len  = 1;
      cnt_high = int'(pwm_o);
    end else if (armed) begin
      cnt_len++;
      cnt_high += int'(pwm_o);
      last_act = int'(duty_act_o);
    end
  end

  task automatic wr_duty(input int d);
    @(negedge clk);
    duty_hi_i = 8'(d >> 2);
    duty_lo_i = 2'(d & 3);
    duty_wr_i = 1'b1;
    @(negedge clk);
    duty_wr_i = 1'b0;
    pend = d;
  endtask

  task automatic wait_match();
    do @(negedge clk); while (match_o !== 1'b1);
  endtask

  // driver: at each cycle start push the expected item, then queue the next duty
  task automatic step(input int nxt, input int a, input int g);
    item_t it;
    int hn;
    wait_match();
    chk(int'(duty_act_o) == pend, "R2 latched duty at match", int'(duty_act_o), pend);
    hn      = exp_high(pend, cur_p, cur_n);
    it.d    = pend;
    it.len  = (cur_p + 1) * 4 * cur_n + g;
    if (g > 0) begin
      it.high = (hn < a + 1) ? hn : a + 1;
      it.tag  = "R8 high time with gap";
    end else begin
      it.high = hn;
      if (pend == 0)                 it.tag = "R6 zero duty";
      else if (pend > 4*cur_p + 3)   it.tag = "R7 full duty";
      else                           it.tag = "R4 high time";
    end
    q.push_back(it);
    if (g > 0) begin
      repeat (a) @(negedge clk);
      en_i = 1'b0;
      for (int i = 0; i < g; i++) begin
        @(negedge clk);
        chk(!pwm_o && !match_o, "R8 disabled outputs", int'({pwm_o, match_o}), 0);
      end
      en_i = 1'b1;
    end
    repeat (3) @(negedge clk);
    wr_duty(nxt);
  endtask

  task automatic cfg(input int p, input logic [1:0] ps, input int n, input int d0);
    @(negedge clk);
    rst      = 1'b1;
    en_i     = 1'b0;
    psel_i   = ps;
    period_i = 8'(p);
    cur_p    = p;
    cur_n    = n;
    repeat (3) @(negedge clk);
    chk(pwm_o == 1'b0, "R9 reset pwm", int'(pwm_o), 0);
    chk(duty_act_o == '0, "R9 reset duty", int'(duty_act_o), 0);
    chk(match_o == 1'b0, "R9 reset match", int'(match_o), 0);
    rst = 1'b0;
    wr_duty(d0);
    en_i = 1'b1;
  endtask

  initial begin
    // 1:1, period 9 -> 40 clocks per cycle, max base 39
    cfg(9, 2'b00, 1, 20);
    step(7, 0, 0);     // R3: 7 = hi 1, lo 3
    step(0, 0, 0);
    step(39, 0, 0);
    step(45, 0, 0);
    step(45, 0, 0);
    step(12, 4, 6);    // R8 gap in a full-duty cycle
    step(12, 0, 0);
    step(12, 0, 0);
    // 1:4, period 5 -> 96 clocks
    cfg(5, 2'b01, 4, 10);
    step(23, 0, 0);
    step(0, 0, 0);
    step(0, 0, 0);
    // 1:16, period 3 -> 256 clocks
    cfg(3, 2'b10, 16, 6);
    step(13, 0, 0);
    step(13, 0, 0);
    step(13, 0, 0);
    // alternate 1:16 code
    cfg(3, 2'b11, 16, 13);
    step(5, 0, 0);
    step(5, 0, 0);
    step(5, 0, 0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule